// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small byte-serial processor whose datapath is eight bits wide. It is a Moore state machine: its outputs depend on its current state alone. It steps the datapath through the phases of each instruction, one phase per clock. First it fetches four instruction bytes one at a time. Next comes a decode phase, which also precomputes a branch target. After that it performs the execution, memory and write-back phases that the instruction needs, and then it returns to fetch.

The sequencer reads only the 6-bit opcode, which the datapath presents from its instruction register. It drives these strobes and selects:

- memory read and memory write;
- the memory-address source;
- a 4-bit per-byte instruction-register load;
- register-file write, destination select and write-data select;
- the two ALU operand selects and a 2-bit ALU operation class;
- the PC source, plus an unconditional and a conditional PC write.

Turning the ALU operation class and the function field into an actual ALU function is done elsewhere.

Inside the block, a phase tracker chooses the next phase and a strobe decoder turns the phase into a bundle of control lines. The thin top module spreads that bundle onto plain output ports.

Top module: `ctrlFsmTop`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) places the sequencer in the first fetch phase. In the first cycle after `rst` falls, the outputs are those of fetch byte 0.
- R2: Fetch lasts four consecutive cycles, with `irWrite` equal to 0001, 0010, 0100 and 1000 in that order, so the least significant instruction byte is loaded first. In each of these cycles the outputs are: `memRead`=1, `addrFromAlu`=0, `aluSrcA`=0 (operand from the PC), `aluSrcB`=01 (constant one), `aluOpClass`=00 (add), `pcWrite`=1 and `pcSource`=00 (ALU result).
- R3: The cycle after the last fetch byte is decode. Its outputs are `aluSrcA`=0, `aluSrcB`=11 (shifted immediate) and `aluOpClass`=00, with every other line low.
- R4: The opcode is sampled at the end of decode, and again at the end of the address phase. Its encodings are: R-type 000000, branch-if-equal 000100, jump 000010, byte load 100000 and byte store 101000. The opcode is ignored during fetch.
- R5: For a byte load or byte store, the address phase drives `aluSrcA`=1 (register A), `aluSrcB`=10 (immediate) and `aluOpClass`=00.
- R6: A byte load next drives `memRead`=1 with `addrFromAlu`=1. It then writes back with `regWrite`=1, `regDstRd`=0 (destination from bits 20:16) and `memToReg`=1.
- R7: A byte store next drives `memWrite`=1 with `addrFromAlu`=1 for one cycle.
- R8: An R-type instruction executes with `aluSrcA`=1, `aluSrcB`=00 (register B) and `aluOpClass`=10 (function field). It then completes with `regWrite`=1, `regDstRd`=1 (destination from bits 15:11) and `memToReg`=0.
- R9: Branch-if-equal drives `aluSrcA`=1, `aluSrcB`=00, `aluOpClass`=01 (subtract), `pcWriteCond`=1 and `pcSource`=01 (ALU output register).
- R10: Jump drives `pcWrite`=1 with `pcSource`=10 (jump target).
- R11: Any other opcode goes from decode straight back to fetch byte 0, with no memory, register or PC write.
- R12: Any line not listed for a phase is low, and `memRead` and `memWrite` are never high together.
- R13: The cycle after the last phase of every instruction is fetch byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| addrFromAlu | output | 1 | Memory address source: 0 = PC, 1 = ALU output register |
| irWrite | output | 4 | Per-byte instruction-register load, bit k loads byte k |
| regWrite | output | 1 | Register-file write strobe |
| regDstRd | output | 1 | Destination select: 1 = bits 15:11, 0 = bits 20:16 |
| memToReg | output | 1 | Register write data: 1 = memory data, 0 = ALU output register |
| aluSrcA | output | 1 | ALU first operand: 0 = PC, 1 = register A |
| aluSrcB | output | 2 | ALU second operand: 00 B, 01 one, 10 immediate, 11 shifted immediate |
| aluOpClass | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pcSource | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write qualified by the ALU zero flag |

## Verification
The bench targets these corner cases:

- **Byte-lane ordering.** A sequencer that loaded the bytes in the wrong order, or skipped a lane, would show a wrong `irWrite` pattern in fetch.
- **Opcode timing.** During fetch the bench drives changing junk opcodes. A design that sampled the opcode too early would branch into the wrong path.
- **Load versus store.** These two opcodes share the address phase. A design that mixed them up would write memory on a load, or write the register file on a store.
- **Unrecognized opcodes.** A sloppy default case would fire a write strobe or linger in an execution phase.
- **Reset in mid-instruction.** A reset that did not restart fetch at byte 0 would leave the next instruction misassembled.
- **Back-to-back instructions.** A terminal phase that failed to return to fetch byte 0 would break the stream of instructions that follows it.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int OP_W     = 6;
  localparam int IR_LANES = 4;
  localparam int IDX_W    = (IR_LANES > 1) ? $clog2(IR_LANES) : 1;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OP_LB    = 6'b100000;
  localparam logic [OP_W-1:0] OP_SB    = 6'b101000;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_ONE   = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  localparam logic [1:0] CLS_ADD   = 2'b00;
  localparam logic [1:0] CLS_SUB   = 2'b01;
  localparam logic [1:0] CLS_FUNCT = 2'b10;

  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_ALUREG = 2'b01;
  localparam logic [1:0] PCS_JUMP   = 2'b10;

  typedef enum logic [3:0] {
    PH_FETCH, PH_DECODE, PH_ADDR, PH_LDRD, PH_LDWB,
    PH_STWR, PH_REX, PH_RWB, PH_BEQ, PH_JMP
  } phase_t;

  typedef struct packed {
    logic                memRead;
    logic                memWrite;
    logic                addrFromAlu;
    logic [IR_LANES-1:0] irWrite;
    logic                regWrite;
    logic                regDstRd;
    logic                memToReg;
    logic                aluSrcA;
    logic [1:0]          aluSrcB;
    logic [1:0]          aluOpClass;
    logic [1:0]          pcSource;
    logic                pcWrite;
    logic                pcWriteCond;
  } strobes_t;

endpackage

// File: rtl/ctrlSeq.sv
module ctrlSeq
  import ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output phase_t          phase,
  output logic [IDX_W-1:0] fetchIdx
);

  phase_t           phaseNxt;
  logic [IDX_W-1:0] idxNxt;
  logic             lastLane;

  assign lastLane = (fetchIdx == IDX_W'(IR_LANES - 1));

  always_comb begin
    phaseNxt = phase;
    idxNxt   = fetchIdx;
    case (phase)
      PH_FETCH: begin
        if (lastLane) begin
          phaseNxt = PH_DECODE;
          idxNxt   = '0;
        end else begin
          idxNxt = fetchIdx + IDX_W'(1);
        end
      end
      PH_DECODE: begin
        case (opcode)
          OP_LB, OP_SB: phaseNxt = PH_ADDR;
          OP_RTYPE:     phaseNxt = PH_REX;
          OP_BEQ:       phaseNxt = PH_BEQ;
          OP_JMP:       phaseNxt = PH_JMP;
          default:      phaseNxt = PH_FETCH;
        endcase
      end
      PH_ADDR: phaseNxt = (opcode == OP_LB) ? PH_LDRD : PH_STWR;
      PH_LDRD: phaseNxt = PH_LDWB;
      PH_REX:  phaseNxt = PH_RWB;
      default: phaseNxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_FETCH;
      fetchIdx <= '0;
    end else begin
      phase    <= phaseNxt;
      fetchIdx <= idxNxt;
    end
  end

endmodule

// File: rtl/ctrlDecode.sv
module ctrlDecode
  import ctrl_pkg::*;
(
  input  phase_t           phase,
  input  logic [IDX_W-1:0] fetchIdx,
  output strobes_t         strobes
);

  logic [IR_LANES-1:0] laneSel;

  for (genvar g = 0; g < IR_LANES; g++) begin : gLane
    assign laneSel[g] = (fetchIdx == IDX_W'(g));
  end

  always_comb begin
    strobes = '0;
    case (phase)
      PH_FETCH: begin
        strobes.memRead    = 1'b1;
        strobes.irWrite    = laneSel;
        strobes.aluSrcB    = SRCB_ONE;
        strobes.aluOpClass = CLS_ADD;
        strobes.pcSource   = PCS_ALU;
        strobes.pcWrite    = 1'b1;
      end
      PH_DECODE: begin
        strobes.aluSrcB    = SRCB_IMMSH;
        strobes.aluOpClass = CLS_ADD;
      end
      PH_ADDR: begin
        strobes.aluSrcA    = 1'b1;
        strobes.aluSrcB    = SRCB_IMM;
        strobes.aluOpClass = CLS_ADD;
      end
      PH_LDRD: begin
        strobes.memRead     = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      PH_LDWB: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = 1'b1;
      end
      PH_STWR: begin
        strobes.memWrite    = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      PH_REX: begin
        strobes.aluSrcA    = 1'b1;
        strobes.aluSrcB    = SRCB_REG;
        strobes.aluOpClass = CLS_FUNCT;
      end
      PH_RWB: begin
        strobes.regWrite = 1'b1;
        strobes.regDstRd = 1'b1;
      end
      PH_BEQ: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluSrcB     = SRCB_REG;
        strobes.aluOpClass  = CLS_SUB;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSource    = PCS_ALUREG;
      end
      PH_JMP: begin
        strobes.pcWrite  = 1'b1;
        strobes.pcSource = PCS_JUMP;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/ctrlFsmTop.sv
module ctrlFsmTop
  import ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     opcode,
  output logic                memRead,
  output logic                memWrite,
  output logic                addrFromAlu,
  output logic [IR_LANES-1:0] irWrite,
  output logic                regWrite,
  output logic                regDstRd,
  output logic                memToReg,
  output logic                aluSrcA,
  output logic [1:0]          aluSrcB,
  output logic [1:0]          aluOpClass,
  output logic [1:0]          pcSource,
  output logic                pcWrite,
  output logic                pcWriteCond
);

  phase_t           phase;
  logic [IDX_W-1:0] fetchIdx;
  strobes_t         strobes;

  ctrlSeq uSeq (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .phase    (phase),
    .fetchIdx (fetchIdx)
  );

  ctrlDecode uDec (
    .phase    (phase),
    .fetchIdx (fetchIdx),
    .strobes  (strobes)
  );

  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign addrFromAlu = strobes.addrFromAlu;
  assign irWrite     = strobes.irWrite;
  assign regWrite    = strobes.regWrite;
  assign regDstRd    = strobes.regDstRd;
  assign memToReg    = strobes.memToReg;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign aluOpClass  = strobes.aluOpClass;
  assign pcSource    = strobes.pcSource;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;

endmodule

// File: rtl/ctrlFsmChk.sv
module ctrlFsmChk
  import ctrl_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                memRead,
  input logic                memWrite,
  input logic                addrFromAlu,
  input logic [IR_LANES-1:0] irWrite,
  input logic                regWrite,
  input logic                memToReg,
  input logic [1:0]          aluSrcB,
  input logic [1:0]          pcSource,
  input logic                pcWrite,
  input logic                pcWriteCond
);

  localparam logic [IR_LANES-1:0] FIRST_LANE = IR_LANES'(1);

  AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irWrite == FIRST_LANE)); // R1

  AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irWrite)); // R2

  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (irWrite != '0 && !irWrite[IR_LANES-1])
      |=> (irWrite == {$past(irWrite[IR_LANES-2:0]), 1'b0})); // R2

  AST_DECODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irWrite[IR_LANES-1] |=> (aluSrcB == SRCB_IMMSH && irWrite == '0 && !memRead)); // R3

  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (memRead && addrFromAlu) |=> (regWrite && memToReg)); // R6

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite)); // R12

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memWrite, regWrite, pcWrite, pcWriteCond})); // R12

  AST_TERMINAL_RETURN: assert property (@(posedge clk) disable iff (rst)
    (memWrite || regWrite || pcWriteCond || (pcWrite && pcSource == PCS_JUMP))
      |=> (irWrite == FIRST_LANE)); // R13

endmodule

bind ctrlFsmTop ctrlFsmChk uChk (
  .clk         (clk),
  .rst         (rst),
  .memRead     (memRead),
  .memWrite    (memWrite),
  .addrFromAlu (addrFromAlu),
  .irWrite     (irWrite),
  .regWrite    (regWrite),
  .memToReg    (memToReg),
  .aluSrcB     (aluSrcB),
  .pcSource    (pcSource),
  .pcWrite     (pcWrite),
  .pcWriteCond (pcWriteCond)
);

// File: tb/tb_ctrlFsmTop.sv
module tb_ctrlFsmTop;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic memRead, memWrite, addrFromAlu, regWrite, regDstRd, memToReg;
  logic aluSrcA, pcWrite, pcWriteCond;
  logic [3:0] irWrite;
  logic [1:0] aluSrcB, aluOpClass, pcSource;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  logic [18:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrlFsmTop dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .memRead(memRead), .memWrite(memWrite), .addrFromAlu(addrFromAlu),
    .irWrite(irWrite), .regWrite(regWrite), .regDstRd(regDstRd),
    .memToReg(memToReg), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB),
    .aluOpClass(aluOpClass), .pcSource(pcSource), .pcWrite(pcWrite),
    .pcWriteCond(pcWriteCond)
  );

  // Vector layout: mr mw iod ir[3:0] rw rd m2r sa sb[1:0] cls[1:0] ps[1:0] pw pwc
  function automatic logic [18:0] pk(input logic mr, mw, iod, input logic [3:0] ir,
                                     input logic rw, rd, m2r, sa, input logic [1:0] sb,
                                     input logic [1:0] cls, ps, input logic pw, pwc);
    return {mr, mw, iod, ir, rw, rd, m2r, sa, sb, cls, ps, pw, pwc};
  endfunction

  function automatic logic [18:0] actual();
    return {memRead, memWrite, addrFromAlu, irWrite, regWrite, regDstRd, memToReg,
            aluSrcA, aluSrcB, aluOpClass, pcSource, pcWrite, pcWriteCond};
  endfunction

  task automatic push(input logic [18:0] v, input string t);
    expQ.push_back(v);
    tagQ.push_back(t);
  endtask

  // Build the expected per-cycle outputs of one instruction.
  task automatic plan(input logic [5:0] op, input string firstTag);
    push(pk(1,0,0,4'b0001,0,0,0,0,2'b01,2'b00,2'b00,1,0), firstTag); // R2 lane 0
    push(pk(1,0,0,4'b0010,0,0,0,0,2'b01,2'b00,2'b00,1,0), "R2");
    push(pk(1,0,0,4'b0100,0,0,0,0,2'b01,2'b00,2'b00,1,0), "R2");
    push(pk(1,0,0,4'b1000,0,0,0,0,2'b01,2'b00,2'b00,1,0), "R2");
    push(pk(0,0,0,4'b0000,0,0,0,0,2'b11,2'b00,2'b00,0,0), "R3");
    case (op)
      6'b100000: begin
        push(pk(0,0,0,4'b0000,0,0,0,1,2'b10,2'b00,2'b00,0,0), "R5/R4");
        push(pk(1,0,1,4'b0000,0,0,0,0,2'b00,2'b00,2'b00,0,0), "R6/R4");
        push(pk(0,0,0,4'b0000,1,0,1,0,2'b00,2'b00,2'b00,0,0), "R6");
      end
      6'b101000: begin
        push(pk(0,0,0,4'b0000,0,0,0,1,2'b10,2'b00,2'b00,0,0), "R5/R4");
        push(pk(0,1,1,4'b0000,0,0,0,0,2'b00,2'b00,2'b00,0,0), "R7/R12");
      end
      6'b000000: begin
        push(pk(0,0,0,4'b0000,0,0,0,1,2'b00,2'b10,2'b00,0,0), "R8/R4");
        push(pk(0,0,0,4'b0000,1,1,0,0,2'b00,2'b00,2'b00,0,0), "R8");
      end
      6'b000100: push(pk(0,0,0,4'b0000,0,0,0,1,2'b00,2'b01,2'b01,0,1), "R9/R4");
      6'b000010: push(pk(0,0,0,4'b0000,0,0,0,0,2'b00,2'b00,2'b10,1,0), "R10/R4");
      default: ; // R11: straight back to fetch
    endcase
  endtask

  task automatic checkNow(input logic [18:0] e, input string t);
    vectors++;
    if (actual() !== e) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", t, actual(), e);
    end
  endtask

  // Apply up to maxCycles queued cycles; junk opcodes during fetch (R4).
  task automatic drain(input logic [5:0] op, input int maxCycles);
    int i = 0;
    while (expQ.size() > 0 && i < maxCycles) begin
      opcode = (i < 4) ? 6'(i * 13 + 5) ^ op : op;
      checkNow(expQ.pop_front(), tagQ.pop_front());
      @(negedge clk);
      i++;
    end
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic runInstr(input logic [5:0] op, input string firstTag);
    plan(op, firstTag);
    drain(op, 100);
  endtask

  task automatic pulseReset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    runInstr(6'b000000, "R1");   // reset state then R-type
    runInstr(6'b000100, "R13");  // branch-if-equal
    runInstr(6'b000010, "R13");  // jump
    runInstr(6'b100000, "R13");  // byte load
    runInstr(6'b101000, "R13");  // byte store
    runInstr(6'b001000, "R13");  // R11 unrecognized
    runInstr(6'b111111, "R11");  // R11 unrecognized, fetch after R11 decode
    runInstr(6'b100001, "R11");  // R11 near-miss of load
    runInstr(6'b101000, "R13");
    runInstr(6'b100000, "R13");  // store then load back to back
    // Reset in the middle of a load (after the address phase): R1
    plan(6'b100000, "R13");
    drain(6'b100000, 6);
    pulseReset();
    runInstr(6'b100000, "R1");
    // Reset during fetch byte 2
    plan(6'b000010, "R13");
    drain(6'b000010, 2);
    pulseReset();
    runInstr(6'b000010, "R1");
    for (int k = 0; k < 6; k++) begin
      runInstr((k % 2 == 0) ? 6'b000000 : 6'b000100, "R13");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule